// File: doc/BRIEF.md
# Virtual-Output-Queue Crossbar Matching Scheduler

This block decides, once per cell slot, which inputs of an N×N input-queued crossbar may send a cell and to which output. Each input keeps a separate queue for every output. A head cell waiting for a busy output therefore never holds back cells bound for other outputs. Every input presents an N-bit occupancy vector, one bit per queue. The scheduler turns the N vectors into a conflict-free pairing, which then drives the crossbar multiplexer selects.

A `start` pulse samples the request matrix. The scheduler then runs a fixed number of request/grant/accept rounds, one round per clock. In a round, every unmatched output offers a grant to one unmatched requester, chosen round-robin from its grant pointer. Every unmatched input that holds offers then takes one of them, chosen round-robin from its accept pointer. Pairs made in one round stay fixed for the rest of the slot. Later rounds only fill in the free inputs and outputs. Pointers advance only on pairs made in the first round, to one position past the partner.

`start` and `done` are plain control pins. They carry no valid/ready handshake and there is no back-pressure. A `start` that arrives while a slot is running is dropped. The match and the output-valid flags stay constant from `done` until the next accepted `start`.

Top module: `voq_sched`

## Requirements
- R1: `match` holds at most one set bit among bits `i*N .. i*N+N-1`. This row is input i, and bit `i*N+j` set means input i is paired with output j.
- R2: For every output j, at most one input i has `match[i*N+j]` set.
- R3: A pair (i,j) appears in `match` only if `req[i*N+j]` was 1 when the slot's `start` was sampled.
- R4: `out_valid[j]` is 1 exactly when some input is paired with output j.
- R5: After the clock edge that accepts `start`, `done` goes high for exactly one cycle, ITERS cycles later.
- R6: A `start` that arrives while a slot is in progress is ignored. It neither restarts the slot nor replaces the sampled requests.
- R7: An output grants to the first requesting unmatched input at or after its grant pointer, in increasing index order with wrap-around. When that grant is accepted in round one, the pointer moves to one past the granted input.
- R8: An input accepts the first offering output at or after its accept pointer, in increasing index order with wrap-around. When it accepts in round one, the pointer moves to one past the accepted output.
- R9: After round one, only inputs and outputs that are still unmatched take part. Pairs already made stay fixed, and later rounds can add new pairs.
- R10: `match` and `out_valid` keep their values from `done` until the next accepted `start`, which clears them.
- R11: Reset clears `match`, `out_valid` and `done`, and sets every grant and accept pointer to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a slot and samples `req` when the scheduler is idle |
| req | input | N*N | Bit i*N+j: queue of input i for output j is non-empty |
| match | output | N*N | Bit i*N+j: input i is paired with output j |
| out_valid | output | N | Bit j: output j has a partner |
| done | output | 1 | One-cycle pulse when the final match is valid |

## Verification
The pointers are internal state, so a pointer that is wrong or moves at the wrong time cannot be seen in the slot where it goes wrong. It first appears one slot later, as a different winner for the same request pattern. The bench therefore plays a fixed sequence of slots with known pointer history, with repeated single-output and single-input contention, so that a wrong pointer changes the very next match. A wrong matched-set update shows up in the same slot, either as a duplicate partner or as a missing fill-in by a later round. An iteration count that is off by one moves `done` by one cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;

  function automatic int wrap_step(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  win,
  output logic [PW-1:0] win_idx,
  output logic          any
);
  int pos;
  always_comb begin
    win     = '0;
    win_idx = '0;
    any     = 1'b0;
    pos     = 0;
    for (int k = 0; k < N; k++) begin
      pos = (int'(ptr) + k) % N;
      if (!any && cand[pos]) begin
        any          = 1'b1;
        win[pos]     = 1'b1;
        win_idx      = PW'(pos);
      end
    end
  end
endmodule

// File: rtl/match_round.sv
module match_round #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N-1:0]  req_q,
  input  logic [N-1:0]    in_free,
  input  logic [N-1:0]    out_free,
  input  logic [N*PW-1:0] gptr,
  input  logic [N*PW-1:0] aptr,
  output logic [N*N-1:0]  acc,
  output logic [N-1:0]    in_won,
  output logic [N-1:0]    out_won,
  output logic [N*PW-1:0] gidx,
  output logic [N*PW-1:0] aidx
);
  logic [N-1:0] col_req [N];
  logic [N-1:0] col_gnt [N];
  logic [N-1:0] row_offer [N];
  logic [N-1:0] row_acc [N];
  logic [N-1:0] g_any;

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col_req[j][i] = req_q[i*N+j] & in_free[i] & out_free[j];
  end

  for (genvar j = 0; j < N; j++) begin : g_grant
    rr_pick #(.N(N)) u_gnt (
      .cand(col_req[j]), .ptr(gptr[j*PW +: PW]),
      .win(col_gnt[j]), .win_idx(gidx[j*PW +: PW]), .any(g_any[j])
    );
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        row_offer[i][j] = col_gnt[j][i];
  end

  for (genvar i = 0; i < N; i++) begin : g_accept
    rr_pick #(.N(N)) u_acc (
      .cand(row_offer[i]), .ptr(aptr[i*PW +: PW]),
      .win(row_acc[i]), .win_idx(aidx[i*PW +: PW]), .any(in_won[i])
    );
  end

  always_comb begin
    out_won = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        acc[i*N+j] = row_acc[i][j];
        out_won[j] = out_won[j] | (row_acc[i][j] & g_any[j]);
      end
  end
endmodule

// File: rtl/voq_sched.sv
module voq_sched #(
  parameter int N     = 4,
  parameter int ITERS = 3,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*N-1:0] req,
  output logic [N*N-1:0] match,
  output logic [N-1:0]   out_valid,
  output logic           done
);
  import sched_pkg::*;

  phase_t          phase;
  logic [IW-1:0]   iter;
  logic [N*N-1:0]  req_q;
  logic [N*N-1:0]  match_q;
  logic [N-1:0]    ovalid_q;
  logic            done_q;
  logic [N*PW-1:0] gptr;
  logic [N*PW-1:0] aptr;

  logic [N-1:0]    in_free;
  logic [N-1:0]    out_free;
  logic [N*N-1:0]  acc;
  logic [N-1:0]    in_won;
  logic [N-1:0]    out_won;
  logic [N*PW-1:0] gidx;
  logic [N*PW-1:0] aidx;

  always_comb begin
    for (int i = 0; i < N; i++)
      in_free[i] = ~|match_q[i*N +: N];
    out_free = ~ovalid_q;
  end

  match_round #(.N(N)) u_round (
    .req_q(req_q), .in_free(in_free), .out_free(out_free),
    .gptr(gptr), .aptr(aptr),
    .acc(acc), .in_won(in_won), .out_won(out_won),
    .gidx(gidx), .aidx(aidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      iter     <= '0;
      req_q    <= '0;
      match_q  <= '0;
      ovalid_q <= '0;
      done_q   <= 1'b0;
      gptr     <= '0;
      aptr     <= '0;
    end else begin
      done_q <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase    <= PH_RUN;
          iter     <= '0;
          req_q    <= req;
          match_q  <= '0;
          ovalid_q <= '0;
        end
      end else begin
        match_q  <= match_q | acc;
        ovalid_q <= ovalid_q | out_won;
        if (iter == '0) begin
          for (int j = 0; j < N; j++)
            if (out_won[j])
              gptr[j*PW +: PW] <= PW'(wrap_step(int'(gidx[j*PW +: PW]), N));
          for (int i = 0; i < N; i++)
            if (in_won[i])
              aptr[i*PW +: PW] <= PW'(wrap_step(int'(aidx[i*PW +: PW]), N));
        end
        if (iter == IW'(ITERS-1)) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end else begin
          iter <= iter + 1'b1;
        end
      end
    end
  end

  assign match     = match_q;
  assign out_valid = ovalid_q;
  assign done      = done_q;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int N     = 4,
  parameter int ITERS = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N*N-1:0] req,
  input logic [N*N-1:0] match,
  input logic [N-1:0]   out_valid,
  input logic           done
);
  logic [N-1:0] col [N];
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col[j][i] = match[i*N+j];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    // R1
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match[i*N +: N]));
  end

  for (genvar j = 0; j < N; j++) begin : g_col
    // R2
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[j]));
    // R4
    ovalid_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] == (|col[j]));
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(match) && $stable(out_valid)));
endmodule

bind voq_sched sched_chk #(.N(N), .ITERS(ITERS)) u_chk (.*);

// File: tb/tb_voq_sched.sv
module tb_voq_sched;
  localparam int N = 4;
  localparam int ITERS = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 10;

  // {req[15:0], expected match[15:0], expected out_valid[3:0]}
  localparam logic [35:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 4'h0},
    {16'hFFFF, 16'h0421, 4'h7},  // R9 fill-in by later rounds
    {16'hFFFF, 16'h8412, 4'hF},  // R7 R8 pointers from previous slot
    {16'h4444, 16'h0004, 4'h4},  // R7 contention on output 2
    {16'h4444, 16'h0040, 4'h4},  // R7
    {16'h4444, 16'h0400, 4'h4},  // R7
    {16'h000F, 16'h0008, 4'h8},  // R8 input 0 offered everything
    {16'h000F, 16'h0001, 4'h1},  // R8 wrap
    {16'h0013, 16'h0012, 4'h3},
    {16'h0013, 16'h0001, 4'h1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*N-1:0] req = '0;
  logic [N*N-1:0] match;
  logic [N-1:0] out_valid;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  voq_sched #(.N(N), .ITERS(ITERS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .match(match), .out_valid(out_valid), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_slot(input logic [N*N-1:0] r, output int cyc);
    @(negedge clk);
    req = r;
    start = 1'b1;
    cyc = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (done) break;
    end
  endtask

  task automatic check_struct(input logic [N*N-1:0] r);
    int rowc;
    int colc;
    bit ok1 = 1'b1;
    bit ok2 = 1'b1;
    bit ok3 = 1'b1;
    bit ok4 = 1'b1;
    for (int i = 0; i < N; i++) begin
      rowc = 0;
      for (int j = 0; j < N; j++) rowc += match[i*N+j];
      if (rowc > 1) ok1 = 1'b0;
    end
    for (int j = 0; j < N; j++) begin
      colc = 0;
      for (int i = 0; i < N; i++) colc += match[i*N+j];
      if (colc > 1) ok2 = 1'b0;
      if (out_valid[j] != (colc != 0)) ok4 = 1'b0;
    end
    if ((match & ~r) != '0) ok3 = 1'b0;
    check(ok1, "R1 one partner per input", 32'(match), 32'(match));
    check(ok2, "R2 one partner per output", 32'(match), 32'(match));
    check(ok3, "R3 pair without request", 32'(match), 32'(r));
    check(ok4, "R4 out_valid vs match", 32'(out_valid), 32'(match));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(match == '0, "R11 match at reset", 32'(match), 0);
    check(out_valid == '0, "R11 out_valid at reset", 32'(out_valid), 0);
    check(done == 1'b0, "R11 done at reset", 32'(done), 0);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      run_slot(VEC[v][35:20], cyc);
      check(cyc == ITERS + 1, "R5 done timing", 32'(cyc), 32'(ITERS + 1));
      check(match == VEC[v][19:4], "R7 R8 R9 match vector", 32'(match), 32'(VEC[v][19:4]));
      check(out_valid == VEC[v][3:0], "R4 out_valid vector", 32'(out_valid), 32'(VEC[v][3:0]));
      check_struct(VEC[v][35:20]);
      @(negedge clk);
      check(done == 1'b0, "R5 done single cycle", 32'(done), 0);
    end

    // R6 start while busy is ignored
    @(negedge clk);
    req = 16'h1248;
    start = 1'b1;
    @(negedge clk);
    req = 16'hFFFF;
    cyc = 1;
    for (int k = 0; k < 20; k++) begin
      if (done) break;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == ITERS + 1, "R6 second start did not restart", 32'(cyc), 32'(ITERS + 1));
    check(match == 16'h1248, "R6 requests not replaced", 32'(match), 32'h1248);
    check(out_valid == 4'hF, "R6 out_valid", 32'(out_valid), 32'hF);

    // R10 hold until next start
    req = 16'h0000;
    repeat (5) @(negedge clk);
    check(match == 16'h1248, "R10 match held", 32'(match), 32'h1248);
    check(out_valid == 4'hF, "R10 out_valid held", 32'(out_valid), 32'hF);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(match == '0, "R10 cleared by start", 32'(match), 0);

    // R11 pointers return to index 0 after reset
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_slot(16'hFFFF, cyc);
    check(match == 16'h0421, "R11 pointers reset", 32'(match), 32'h0421);
    check(out_valid == 4'h7, "R11 out_valid after reset", 32'(out_valid), 32'h7);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule